// File: doc/BRIEF.md
# Conditional Branch Execution Unit

This unit carries out a compare-free conditional branch on a 64-bit integer register. Each valid request supplies the register's current value, a 32-bit immediate, a 4-bit condition field and a jump target. The unit derives a bit position from the condition field and a compile-time offset. It sign-extends the immediate and forces two bits of it around that position, then adds the result to the register value. The sum is returned as the new register value. The branch is taken when a window of bits in the sum, starting at the derived position, is all zero.

The unit does not choose the operand register and does not fetch instructions. The surrounding datapath feeds the returned sum back into its register file and redirects the program counter with the target when the taken flag is set. One bit of the immediate is forced to 1 at the window base and the bit just below it is forced to 0. Together these two forced bits guarantee that repeating the same branch on its own result can take at most two jumps in a row.

The adder and the window test are combinational. The result is captured in one output register stage. The window width and the window offset are parameters, and they are checked when the design is elaborated.

Top module: `cond_branch_unit`

## Requirements
- R1: The window base position is p = cond + MASK_OFFSET (MASK_OFFSET defaults to 8). Bit 0 is the least significant bit.
- R2: The shaped immediate is the 32-bit immediate sign-extended to 64 bits, with bit p set to 1 and, when p > 0, bit p-1 cleared to 0. All other bits are those of the sign-extended immediate.
- R3: sum_out equals reg_value plus the shaped immediate, modulo 2^64.
- R4: taken is 1 exactly when bits p through p+MASK_BITS-1 of the sum are all zero (MASK_BITS defaults to 8).
- R5: target_out equals target_in when taken is 1, and 0 when taken is 0.
- R6: sum_out, taken, target_out and out_valid are updated on the rising edge at which in_valid is 1. out_valid is 1 for exactly the cycle after each valid request.
- R7: While in_valid is 0, out_valid is 0 and sum_out, taken and target_out keep their values, whatever the other inputs do.
- R8: A synchronous active-high reset clears out_valid, sum_out, taken and target_out to 0.
- R9: Feeding sum_out back as reg_value with the same immediate and condition field never gives more than two taken results in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the operands are captured on this edge |
| reg_value | input | DATA_W (64) | Current value of the operand register |
| imm | input | IMM_W (32) | Signed immediate of the branch |
| cond | input | COND_W (4) | Condition field selecting the window position |
| target_in | input | TGT_W (8) | Jump target passed through on a taken branch |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| sum_out | output | DATA_W (64) | Updated register value |
| taken | output | 1 | Branch is taken |
| target_out | output | TGT_W (8) | target_in when taken, else 0 |

## Verification
Every result of a request is due one clock after the edge that captures it. The bench drives each request on a falling edge and drops in_valid on the next falling edge. It reads out_valid, sum_out, taken and target_out at that second falling edge, half a period after the loading edge. One falling edge later it reads the outputs again to confirm that out_valid has fallen and the values are held, while the input operands have been scrambled. A second instance with a zero offset and a 4-bit window covers the case p = 0. In the feedback runs, each sum read back is driven as the next register value, so the count of consecutive taken results follows the one-cycle cadence.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Largest combined window width plus offset the unit accepts.
  localparam int unsigned CBU_MAX_SPAN = 16;

  function automatic bit cbu_params_ok(input int win_bits, input int win_off);
    return (win_bits > 0) && (win_off >= 0) && ((win_bits + win_off) <= CBU_MAX_SPAN);
  endfunction

endpackage

// File: rtl/cbu_imm_shaper.sv
module cbu_imm_shaper #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int COND_W = 4,
  parameter int OFFSET = 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [COND_W-1:0] cond,
  output logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] shaped
);

  logic [DATA_W-1:0] ext;

  assign pos = POS_W'(cond) + POS_W'(OFFSET);
  assign ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  // A nonzero offset means the base is never 0, so the clear is unconditional.
  generate
    if (OFFSET > 0) begin : g_always_clear
      always_comb begin
        shaped = ext;
        shaped[pos] = 1'b1;
        shaped[pos - POS_W'(1)] = 1'b0;
      end
    end else begin : g_guarded_clear
      always_comb begin
        shaped = ext;
        shaped[pos] = 1'b1;
        if (pos != '0) shaped[pos - POS_W'(1)] = 1'b0;
      end
    end
  endgenerate

  // Only the base bit and the bit under it may differ from the sign-extended value.
  logic [DATA_W-1:0] touch_mask;
  always_comb begin
    touch_mask = '0;
    touch_mask[pos] = 1'b1;
    if (pos != '0) touch_mask[pos - POS_W'(1)] = 1'b1;
    if (!$isunknown({imm, cond})) begin
      AST_ONLY_TWO_BITS_CHANGE: assert (((shaped ^ ext) & ~touch_mask) == '0) else $error("shaper changed extra bits"); // R2
    end
  end

endmodule

// File: rtl/cbu_window_test.sv
module cbu_window_test #(
  parameter int DATA_W = 64,
  parameter int MASK_BITS = 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] sum,
  input  logic [POS_W-1:0]  pos,
  output logic              all_zero
);

  logic [DATA_W-1:0] aligned;

  assign aligned  = sum >> pos;
  assign all_zero = ~|aligned[MASK_BITS-1:0];

endmodule

// File: rtl/cbu_out_stage.sv
module cbu_out_stage #(
  parameter int DATA_W = 64,
  parameter int TGT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sum_d,
  input  logic              taken_d,
  input  logic [TGT_W-1:0]  target_d,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum_q,
  output logic              taken_q,
  output logic [TGT_W-1:0]  target_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum_q     <= '0;
      taken_q   <= 1'b0;
      target_q  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_q    <= sum_d;
        taken_q  <= taken_d;
        target_q <= taken_d ? target_d : '0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_q) && $stable(taken_q) && $stable(target_q))); // R7
  AST_TARGET_GATED: assert property (@(posedge clk) disable iff (rst) !taken_q |-> (target_q == '0)); // R5

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int DATA_W      = 64,
  parameter int IMM_W       = 32,
  parameter int COND_W      = 4,
  parameter int TGT_W       = 8,
  parameter int MASK_BITS   = 8,
  parameter int MASK_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] reg_value,
  input  logic [IMM_W-1:0]  imm,
  input  logic [COND_W-1:0] cond,
  input  logic [TGT_W-1:0]  target_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum_out,
  output logic              taken,
  output logic [TGT_W-1:0]  target_out
);
  import cbu_pkg::*;

  localparam int POS_W   = $clog2(DATA_W);
  localparam int TOP_BIT = (1 << COND_W) - 1 + MASK_OFFSET + MASK_BITS;

  generate
    if (!cbu_params_ok(MASK_BITS, MASK_OFFSET)) begin : g_bad_window
      $error("window width must be positive, offset non-negative, and their sum at most 16");
    end
    if (TOP_BIT > DATA_W || IMM_W > DATA_W) begin : g_bad_width
      $error("window or immediate does not fit in the register width");
    end
  endgenerate

  logic [POS_W-1:0]  pos;
  logic [DATA_W-1:0] shaped;
  logic [DATA_W-1:0] sum_d;
  logic              zero_d;

  cbu_imm_shaper #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .COND_W(COND_W), .OFFSET(MASK_OFFSET)
  ) u_shaper (
    .imm(imm), .cond(cond), .pos(pos), .shaped(shaped)
  );

  assign sum_d = reg_value + shaped;

  cbu_window_test #(
    .DATA_W(DATA_W), .MASK_BITS(MASK_BITS)
  ) u_window (
    .sum(sum_d), .pos(pos), .all_zero(zero_d)
  );

  cbu_out_stage #(
    .DATA_W(DATA_W), .TGT_W(TGT_W)
  ) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .sum_d(sum_d), .taken_d(zero_d), .target_d(target_in),
    .out_valid(out_valid), .sum_q(sum_out), .taken_q(taken), .target_q(target_out)
  );

  AST_SUM_PATH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (sum_out == $past(reg_value + shaped))); // R3
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!taken || (target_out == $past(target_in)))); // R5

endmodule

// File: tb/tb_cond_branch_unit.sv
module tb_cond_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TGT_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] reg_value = '0;
  logic [31:0] imm = '0;
  logic [3:0]  cond = '0;
  logic [TGT_W-1:0] target_in = '0;

  logic        ov_a, tk_a, ov_z, tk_z;
  logic [63:0] sum_a, sum_z;
  logic [TGT_W-1:0] tg_a, tg_z;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_branch_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .reg_value(reg_value), .imm(imm),
    .cond(cond), .target_in(target_in), .out_valid(ov_a), .sum_out(sum_a),
    .taken(tk_a), .target_out(tg_a));

  cond_branch_unit #(.MASK_BITS(4), .MASK_OFFSET(0)) dut_zoff (
    .clk(clk), .rst(rst), .in_valid(in_valid), .reg_value(reg_value), .imm(imm),
    .cond(cond), .target_in(target_in), .out_valid(ov_z), .sum_out(sum_z),
    .taken(tk_z), .target_out(tg_z));

  function automatic logic [63:0] shape(input logic [31:0] i, input logic [3:0] c, input int off);
    logic [63:0] s;
    int p;
    p = int'(c) + off;
    s = {{32{i[31]}}, i};
    s[p] = 1'b1;
    if (p > 0) s[p-1] = 1'b0;
    return s;
  endfunction

  function automatic bit win_zero(input logic [63:0] s, input int p, input int bits);
    return ((s >> p) & ((64'd1 << bits) - 64'd1)) == 64'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
  function automatic logic [63:0] nxt(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // One request; checks both instances one clock later, then the hold state.
  task automatic apply(input logic [63:0] r, input logic [31:0] i, input logic [3:0] c,
                       input logic [TGT_W-1:0] t);
    logic [63:0] ea, ez;
    bit ka, kz;
    @(negedge clk);
    reg_value = r; imm = i; cond = c; target_in = t; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    reg_value = ~r; imm = ~i; cond = ~c; target_in = ~t;
    ea = r + shape(i, c, 8);
    ez = r + shape(i, c, 0);
    ka = win_zero(ea, int'(c) + 8, 8);
    kz = win_zero(ez, int'(c), 4);
    chk("R6 out_valid", 64'(ov_a), 64'd1);
    chk("R3 sum", sum_a, ea);
    chk("R4 taken", 64'(tk_a), 64'(ka));
    chk("R5 target", 64'(tg_a), ka ? 64'(t) : 64'd0);
    chk("R6 out_valid zoff", 64'(ov_z), 64'd1);
    chk("R3 sum zoff", sum_z, ez);
    chk("R4 taken zoff", 64'(tk_z), 64'(kz));
    chk("R5 target zoff", 64'(tg_z), kz ? 64'(t) : 64'd0);
    @(negedge clk);
    chk("R7 valid low", 64'(ov_a), 64'd0);
    chk("R7 sum held", sum_a, ea);
    chk("R7 taken held", 64'(tk_a), 64'(ka));
    chk("R7 sum held zoff", sum_z, ez);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'h00FF_FF00;
    pats[6] = 32'hF0F0_0F0F; pats[7] = 32'h1234_5678;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: state after reset
    chk("R8 out_valid", 64'(ov_a), 64'd0);
    chk("R8 sum", sum_a, 64'd0);
    chk("R8 taken", 64'(tk_a), 64'd0);
    chk("R8 target", 64'(tg_a), 64'd0);

    // R1 R2: with a zero register the sum is the shaped immediate itself.
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 8; k++) begin
        apply(64'd0, pats[k], 4'(c), TGT_W'(c * 8 + k));
        chk("R1 R2 shaped", sum_a, shape(pats[k], 4'(c), 8));
        chk("R1 R2 shaped zoff", sum_z, shape(pats[k], 4'(c), 0));
      end
    end

    // R3 R4 R5: random registers, and registers aimed at an empty window.
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic [63:0] base;
        seed = nxt(seed);
        apply(seed, pats[k] ^ seed[63:32], 4'(c), TGT_W'(seed[7:0]));
        seed = nxt(seed);
        base = seed & ~(64'hFF << (c + 8));
        apply(base - shape(pats[k], 4'(c), 8), pats[k], 4'(c), TGT_W'(k + 1));
        chk("R4 forced taken", 64'(tk_a), 64'd1);
        seed = nxt(seed);
        base = seed & ~(64'hF << c);
        apply(base - shape(pats[k], 4'(c), 0), pats[k], 4'(c), TGT_W'(k + 2));
        chk("R4 forced taken zoff", 64'(tk_z), 64'd1);
      end
    end

    // R9: repeat one branch on its own result; at most two taken in a row.
    for (int c = 0; c < 16; c += 3) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] iv;
        logic [63:0] r;
        int streak;
        iv = (32'hFF << (c + 8)) | ((32'd1 << (c + 7)) - 32'd1 - 32'(k));
        r = 64'd0 - shape(iv, 4'(c), 8);
        streak = 0;
        for (int n = 0; n < 24; n++) begin
          apply(r, iv, 4'(c), 8'hA5);
          streak = tk_a ? streak + 1 : 0;
          chk("R9 streak", 64'(streak > 2), 64'd0);
          r = sum_a;
        end
      end
    end

    // R8: reset in the middle of a run clears a loaded result.
    apply(64'd0 - shape(32'd0, 4'd0, 8), 32'd0, 4'd0, 8'h3C);
    chk("R8 pre-reset taken", 64'(tk_a), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mid sum", sum_a, 64'd0);
    chk("R8 mid taken", 64'(tk_a), 64'd0);
    chk("R8 mid target", 64'(tg_a), 64'd0);
    chk("R8 mid valid", 64'(ov_a), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule